// File: doc/BRIEF.md
# Compare-and-Swap Retry Adder

This engine performs an atomic add on one shared memory word. It has no read-modify-write path of its own. The only atomic operation it uses is a compare-and-swap request on its memory channel. A requester gives it an address and a two's-complement addend. The engine then runs attempts until one of them lands.

In each attempt the engine reads the word with an ordinary load. It then forms the sum and offers a compare-and-swap. That request carries the loaded value as the expected contents and the sum as the replacement. Memory answers with the contents it found and a success flag.

If another writer changed the word between the load and the swap, the swap is refused. The engine then stays off the channel for a backoff window. The window doubles with each consecutive refusal, up to a cap. After the window the engine repeats the whole attempt with a fresh load. When a swap succeeds, the engine returns the value it stored and the number of swap attempts it made.

Top module: `cas_add_engine`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `mem_req_valid` are low and `cmd_ready` is high.
- R2: `cmd_ready` is high only while the engine is idle. A `cmd_valid` raised while busy is ignored: the result and the stored word depend only on the accepted command.
- R3: Each attempt first issues a load (`mem_req_op`=0) to the commanded address. It then issues a compare-and-swap (`mem_req_op`=1) whose `mem_req_cmp` equals the loaded data and whose `mem_req_swap` equals that data plus the addend.
- R4: A refused swap (`mem_rsp_ok`=0) leads, after the backoff window, to a fresh load, and the attempt is repeated in full.
- R5: On a successful swap, `rsp_valid` is high for exactly one cycle. In that cycle `rsp_value` equals the swapped-in value, and `busy` falls in the next cycle.
- R6: The addend is two's-complement and the sum wraps modulo 2^DW. A negative addend decrements the word.
- R7: Count the cycles with no memory request that lie strictly between the cycle carrying the k-th consecutive refusal (k from 1) and the cycle carrying the re-load. That count is min(2^(k-1), 256).
- R8: A success restores the window to 1 cycle, so the first refusal of the next command waits 1 cycle.
- R9: `rsp_tries` equals the number of compare-and-swap requests issued for the command, saturating at 255.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and all of its fields stay unchanged in the next cycle.
- R11: `busy` is high from the cycle after command acceptance through the `rsp_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken on valid |
| cmd_addr | input | AW | Address of the shared word |
| cmd_addend | input | DW | Two's-complement addend |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_value | output | DW | Value stored by the winning swap |
| rsp_tries | output | TRY_W | Swap attempts, saturating |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_op | output | 1 | 0 load, 1 compare-and-swap |
| mem_req_addr | output | AW | Request address |
| mem_req_cmp | output | DW | Expected contents for swap |
| mem_req_swap | output | DW | Replacement value for swap |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_data | input | DW | Contents found at the address |
| mem_rsp_ok | input | 1 | Swap took place |

## Verification
The hardest states to reach are the long runs of refusals. These are the ones that drive the backoff window to its cap and the attempt count past its saturation point. From the ports they need another writer that wins every race. The bench memory model plays that writer. It holds a budget of interfering writes. For each compare-and-swap it serves while the budget is nonzero, it bumps the word before comparing. A budget of ten is used to measure every window size, and a budget of three hundred drives the counter into saturation.

// File: rtl/cas_add_pkg.sv
package cas_add_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_CAS_REQ,
    ST_CAS_WAIT,
    ST_BACKOFF,
    ST_DONE
  } eng_state_t;

  localparam logic OP_LOAD = 1'b0;
  localparam logic OP_CAS  = 1'b1;
endpackage

// File: rtl/cas_backoff.sv
module cas_backoff #(
  parameter int CAP_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail_i,
  input  logic              succ_i,
  output logic              last_o,
  output logic [CAP_LOG2:0] window_o
);
  localparam int WW = CAP_LOG2 + 1;
  localparam logic [WW-1:0] CAP_WIN = {1'b1, {CAP_LOG2{1'b0}}};
  localparam logic [WW-1:0] MIN_WIN = WW'(1);

  logic [WW-1:0] window_q;
  logic [WW-1:0] count_q;

  // doubling with a ceiling
  function automatic logic [WW-1:0] grow(input logic [WW-1:0] w);
    return (w >= CAP_WIN) ? CAP_WIN : (w << 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      window_q <= MIN_WIN;
      count_q  <= '0;
    end else if (fail_i) begin
      count_q  <= window_q;
      window_q <= grow(window_q);
    end else begin
      if (succ_i) window_q <= MIN_WIN;
      if (count_q != '0) count_q <= count_q - WW'(1);
    end
  end

  assign last_o   = (count_q == WW'(1));
  assign window_o = window_q;

  AST_WIN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(window_q)); // R7
  AST_WIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    fail_i |=> window_q <= CAP_WIN); // R7
  AST_WIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    succ_i && !fail_i |=> window_q == MIN_WIN); // R8
endmodule

// File: rtl/cas_try_counter.sv
module cas_try_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] count_q;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] c);
    return (c == TOP) ? TOP : c + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      count_q <= '0;
    else if (clr_i)  count_q <= '0;
    else if (inc_i)  count_q <= sat_inc(count_q);
  end

  assign count_o = count_q;

  AST_TRIES_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i && !clr_i && count_q == TOP |=> count_q == TOP); // R9
  AST_TRIES_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> count_q == '0); // R9
endmodule

// File: rtl/cas_add_engine.sv
module cas_add_engine
  import cas_add_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 16,
  parameter int CAP_LOG2 = 8,
  parameter int TRY_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_addend,
  output logic             busy,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_value,
  output logic [TRY_W-1:0] rsp_tries,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_op,
  output logic [AW-1:0]    mem_req_addr,
  output logic [DW-1:0]    mem_req_cmp,
  output logic [DW-1:0]    mem_req_swap,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  input  logic             mem_rsp_ok
);
  eng_state_t     state_q, state_d;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  addend_q;
  logic [DW-1:0]  seen_q;
  logic [DW-1:0]  sum;

  // named events
  logic cmd_take, rd_take, cas_take, rd_back, cas_ok, cas_fail, in_backoff, bo_last;
  logic [CAP_LOG2:0] bo_window;

  function automatic logic [DW-1:0] add_wrap(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  assign sum        = add_wrap(seen_q, addend_q);
  assign cmd_take   = (state_q == ST_IDLE) && cmd_valid;
  assign rd_take    = (state_q == ST_RD_REQ) && mem_req_ready;
  assign cas_take   = (state_q == ST_CAS_REQ) && mem_req_ready;
  assign rd_back    = (state_q == ST_RD_WAIT) && mem_rsp_valid;
  assign cas_ok     = (state_q == ST_CAS_WAIT) && mem_rsp_valid && mem_rsp_ok;
  assign cas_fail   = (state_q == ST_CAS_WAIT) && mem_rsp_valid && !mem_rsp_ok;
  assign in_backoff = (state_q == ST_BACKOFF);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (cmd_take) state_d = ST_RD_REQ;
      ST_RD_REQ:   if (rd_take)  state_d = ST_RD_WAIT;
      ST_RD_WAIT:  if (rd_back)  state_d = ST_CAS_REQ;
      ST_CAS_REQ:  if (cas_take) state_d = ST_CAS_WAIT;
      ST_CAS_WAIT: begin
        if (cas_ok)        state_d = ST_DONE;
        else if (cas_fail) state_d = ST_BACKOFF;
      end
      ST_BACKOFF:  if (bo_last)  state_d = ST_RD_REQ;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      addend_q <= '0;
      seen_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_take) begin
        addr_q   <= cmd_addr;
        addend_q <= cmd_addend;
      end
      if (rd_back) seen_q <= mem_rsp_data;
    end
  end

  cas_backoff #(.CAP_LOG2(CAP_LOG2)) u_backoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .fail_i   (cas_fail),
    .succ_i   (cas_ok),
    .last_o   (bo_last),
    .window_o (bo_window)
  );

  cas_try_counter #(.W(TRY_W)) u_tries (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cmd_take),
    .inc_i   (cas_take),
    .count_o (rsp_tries)
  );

  assign cmd_ready     = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_value     = sum;
  assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_CAS_REQ);
  assign mem_req_op    = (state_q == ST_CAS_REQ) ? OP_CAS : OP_LOAD;
  assign mem_req_addr  = addr_q;
  assign mem_req_cmp   = seen_q;
  assign mem_req_swap  = sum;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_op)
      && $stable(mem_req_addr) && $stable(mem_req_cmp) && $stable(mem_req_swap)); // R10
  AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy); // R11
  AST_RSP_END: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy && !rsp_valid); // R5
  AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy); // R11
  AST_BACKOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_backoff |-> !mem_req_valid); // R7
  AST_FAIL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    cas_fail |=> in_backoff && !rsp_valid); // R4
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy && !mem_req_valid); // R2
endmodule

// File: tb/sim_cas_add_engine.sv
module sim_cas_add_engine;
  localparam int DW = 32;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_addend = '0;
  logic          busy, rsp_valid;
  logic [DW-1:0] rsp_value;
  logic [7:0]    rsp_tries;
  logic          mem_req_valid, mem_req_op;
  logic          mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_cmp, mem_req_swap;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          mem_rsp_ok = 1'b0;

  always #5 clk = ~clk;

  cas_add_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_addend(cmd_addend), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_value(rsp_value), .rsp_tries(rsp_tries),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
    .mem_req_cmp(mem_req_cmp), .mem_req_swap(mem_req_swap),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_ok(mem_rsp_ok)
  );

  int checks = 0;
  int fails  = 0;

  // bench-owned controls for the memory model
  logic          load_req = 1'b0;
  logic [DW-1:0] load_val = '0;
  int            load_fail = 0;
  logic          stall_mode = 1'b0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_addend = '0;

  // memory model state
  logic [DW-1:0] mem_val = '0;
  int            interfere = 0;
  logic [DW-1:0] last_rd = '0;
  int            bad_cas = 0;
  int            bad_addr = 0;
  int            loads = 0;
  int            stalled = 0;
  int            hold_err = 0;
  logic          was_stalled = 1'b0;
  logic [DW-1:0] st_cmp = '0, st_swap = '0;
  logic          st_op = 1'b0;

  always @(posedge clk) begin
    logic [DW-1:0] cur;
    mem_rsp_valid <= 1'b0;
    mem_rsp_ok    <= 1'b0;
    if (load_req) begin
      mem_val   <= load_val;
      interfere <= load_fail;
      loads     <= 0;
    end
    if (was_stalled && (!mem_req_valid || mem_req_op != st_op ||
        mem_req_cmp != st_cmp || mem_req_swap != st_swap))
      hold_err <= hold_err + 1;
    was_stalled <= mem_req_valid && !mem_req_ready;
    st_op   <= mem_req_op;
    st_cmp  <= mem_req_cmp;
    st_swap <= mem_req_swap;
    if (mem_req_valid && !mem_req_ready) stalled <= stalled + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_addr != exp_addr) bad_addr <= bad_addr + 1;
      mem_rsp_valid <= 1'b1;
      if (mem_req_op == 1'b0) begin
        mem_rsp_data <= mem_val;
        last_rd      <= mem_val;
        loads        <= loads + 1;
      end else begin
        if (mem_req_cmp != last_rd || mem_req_swap != mem_req_cmp + exp_addend)
          bad_cas <= bad_cas + 1;
        cur = mem_val;
        if (interfere > 0) begin
          cur = mem_val + 1;
          interfere <= interfere - 1;
        end
        mem_rsp_data <= cur;
        if (cur == mem_req_cmp) begin
          mem_rsp_ok <= 1'b1;
          mem_val    <= mem_req_swap;
        end else begin
          mem_val <= cur;
        end
      end
    end
    mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
  end

  // gap monitor
  int cyc = 0;
  int fail_cyc = -1;
  int gaps [0:15];
  int gap_n = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_rsp_valid && !mem_rsp_ok && u0_is_cas_rsp) fail_cyc <= cyc;
    if (mem_req_valid && mem_req_op == 1'b0 && fail_cyc >= 0) begin
      if (gap_n < 16) gaps[gap_n] <= cyc - fail_cyc - 1;
      gap_n    <= gap_n + 1;
      fail_cyc <= -1;
    end
  end
  // a failing response is only produced for swaps; loads always carry ok=0
  logic u0_is_cas_rsp = 1'b0;
  always @(posedge clk) u0_is_cas_rsp <= mem_req_valid && mem_req_ready && mem_req_op;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [DW-1:0] init, input logic [DW-1:0] addend,
                         input int nfail, input bit noise,
                         output logic [DW-1:0] val, output int tries, output int bsy_ok);
    int t;
    @(negedge clk);
    load_val = init; load_fail = nfail; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    gap_n = 0;
    exp_addr = 16'h0A0 + AW'(init[3:0]);
    exp_addend = addend;
    cmd_addr = exp_addr; cmd_addend = addend; cmd_valid = 1'b1;
    @(negedge clk);
    bsy_ok = busy && !cmd_ready;
    if (noise) cmd_addend = 32'd999;
    else cmd_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 120000) begin
      if (!busy || cmd_ready) bsy_ok = 0;
      @(negedge clk);
      t++;
    end
    cmd_valid = 1'b0;
    val = rsp_value;
    tries = rsp_tries;
    if (!busy) bsy_ok = 0;
    @(negedge clk);
    if (busy || rsp_valid) bsy_ok = 0;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 mem_req_valid", mem_req_valid, 0);
    check("R1 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_basic();
    logic [DW-1:0] v; int n, b;
    run_cmd(32'd100, 32'd5, 0, 1'b0, v, n, b);
    check("R5 value", v, 105);
    check("R5 memory", mem_val, 105);
    check("R9 tries", n, 1);
    check("R11 busy window", b, 1);
    check("R3 swap fields", bad_cas, 0);
    check("R3 address", bad_addr, 0);
  endtask

  task automatic t_negative();
    logic [DW-1:0] v; int n, b;
    run_cmd(32'd10, -32'sd3, 0, 1'b0, v, n, b);
    check("R6 decrement", v, 7);
    run_cmd(32'd0, -32'sd1, 0, 1'b0, v, n, b);
    check("R6 wrap down", v, 32'hFFFF_FFFF);
    run_cmd(32'hFFFF_FFFF, 32'd2, 0, 1'b0, v, n, b);
    check("R6 wrap up", v, 1);
  endtask

  task automatic t_retry();
    logic [DW-1:0] v; int n, b;
    run_cmd(32'd50, 32'd7, 10, 1'b0, v, n, b);
    check("R4 value after retries", v, 67);
    check("R4 reload count", loads, 11);
    check("R9 tries", n, 11);
    check("R3 swap fields", bad_cas, 0);
    for (int k = 0; k < 10; k++)
      check($sformatf("R7 gap %0d", k), gaps[k], (k >= 8) ? 256 : (1 << k));
  endtask

  task automatic t_window_reset();
    logic [DW-1:0] v; int n, b;
    run_cmd(32'd3, 32'd1, 1, 1'b0, v, n, b);
    check("R8 first gap", gaps[0], 1);
    check("R8 value", v, 5);
  endtask

  task automatic t_ignore();
    logic [DW-1:0] v; int n, b;
    run_cmd(32'd20, 32'd4, 2, 1'b1, v, n, b);
    check("R2 value", v, 26);
    check("R2 memory", mem_val, 26);
    check("R2 not ready while busy", b, 1);
  endtask

  task automatic t_stall();
    logic [DW-1:0] v; int n, b;
    stall_mode = 1'b1;
    run_cmd(32'd40, 32'd9, 1, 1'b0, v, n, b);
    stall_mode = 1'b0;
    check("R10 stalls seen", stalled > 0, 1);
    check("R10 held", hold_err, 0);
    check("R10 value", v, 50);
  endtask

  task automatic t_saturate();
    logic [DW-1:0] v; int n, b;
    run_cmd(32'd1000, 32'd1, 300, 1'b0, v, n, b);
    check("R9 saturated", n, 255);
    check("R4 value", v, 1301);
    check("R3 swap fields", bad_cas, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_negative();
    t_retry();
    t_window_reset();
    t_ignore();
    t_stall();
    t_saturate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule